// File: doc/BRIEF.md
# Multicycle Instruction Controller with Trap Entry

This block is the hardwired sequencer for a multicycle processor that shares one memory and one ALU between all steps of an instruction. It walks each instruction through fetch, decode, execute, memory access and register write-back, and in each state it drives the datapath strobes and multiplexer selects. It handles register-to-register arithmetic, OR with an immediate, word load, word store, branch on equal and jump.

Three trap states sit beside the normal flow. One is for an opcode the decoder does not recognise. One is for signed overflow in a register-to-register operation. One is for an external interrupt. Each trap state drives the ALU to form PC minus 4 into the exception PC register. It loads a cause code and steers a fixed handler address into the PC. Control then resumes at fetch. The datapath, memory and register file are outside the block. Only the state register and the control outputs are modelled.

Top module: `mctrap_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state after that edge is fetch (code 0000). In fetch, the block asserts `mem_rd`, `ir_load` and `pc_load`, with `pc_src`=0 (ALU result), `alu_b_sel`=1 (constant 4) and `alu_func`=0 (add).
- R2: The state after fetch is always decode (0001). In decode, `alu_b_sel`=3 (shifted immediate), `imm_sign`=1 and `alu_func`=0.
- R3: Decode moves to a state chosen by `opcode`. 000000 goes to 0100, 001101 goes to 0110, 100011 goes to 1000, 101011 goes to 1011, 000100 goes to 0010 and 000010 goes to 0011. Every other opcode goes to 1101.
- R4: State 0100 drives `alu_a_reg`=1, `alu_b_sel`=0 and `alu_func`=2 (function field). Without overflow it moves to 0101, which asserts `rf_wr` and `rf_dst_rd` with `rf_from_mem`=0.
- R5: If `alu_ovf` is high in 0100, the next state is 1110 and `rf_wr` stays low in that cycle.
- R6: State 0110 drives `alu_a_reg`=1, `alu_b_sel`=2, `imm_sign`=0 and `alu_func`=3 (OR). It moves to 0111, which asserts `rf_wr` with `rf_dst_rd`=0.
- R7: Load runs 1000, then 1001, then 1010. State 1000 drives `alu_a_reg`=1, `alu_b_sel`=2, `imm_sign`=1 and `alu_func`=0. State 1001 asserts `mem_rd` and `addr_from_alu`. State 1010 asserts `rf_wr` and `rf_from_mem`.
- R8: Store runs 1011, then 1100. State 1011 drives the same address strobes as 1000. State 1100 asserts `mem_wr` and `addr_from_alu`, and never `rf_wr`.
- R9: State 0010 drives `alu_a_reg`=1, `alu_b_sel`=0, `alu_func`=1 (subtract) and `pc_src`=1 (ALU output register). In that state `pc_load` equals `alu_zero`.
- R10: State 0011 asserts `pc_load` with `pc_src`=2 (jump target).
- R11: Every trap state asserts `epc_wr`, `cause_wr` and `pc_load`, with `pc_src`=3, `alu_a_reg`=0, `alu_b_sel`=1 and `alu_func`=1, so that the ALU forms PC-4. `cause_code` is 10 in 1101, 12 in 1110 and 0 in 1111. `trap_target` is 0x80000080.
- R12: `irq` is acted on only in the last state of an instruction (0101, 0111, 1010, 1100, 0010 or 0011). There, a high `irq` leads to 1111 instead of fetch. In every other state, `irq` has no effect on the next state.
- R13: Each trap state is followed by fetch.
- R14: In every state, any strobe not named for that state in R1 to R11 is 0, and so is any select or code not named there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result is zero |
| alu_ovf | input | 1 | ALU signed overflow |
| irq | input | 1 | External interrupt request |
| state_q | output | 4 | Current state code |
| pc_load | output | 1 | Write enable of the PC, with the branch condition already applied |
| pc_src | output | 2 | PC source: 0 ALU, 1 ALU output register, 2 jump target, 3 handler |
| addr_from_alu | output | 1 | Memory address taken from the ALU output register instead of the PC |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register write |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination is the rd field, otherwise rt |
| rf_from_mem | output | 1 | Write data from the memory data register, otherwise from the ALU output |
| alu_a_reg | output | 1 | ALU A operand from register A, otherwise the PC |
| alu_b_sel | output | 2 | ALU B operand: 0 register B, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| imm_sign | output | 1 | Sign-extend the immediate, otherwise zero-extend |
| alu_func | output | 2 | ALU operation: 0 add, 1 subtract, 2 function field, 3 OR |
| epc_wr | output | 1 | Exception PC write |
| cause_wr | output | 1 | Cause register write |
| cause_code | output | 5 | Value written to the cause register |
| trap_target | output | 32 | Fixed handler address |

## Verification
Each control output is a decode of the state register, so an output is due in the same cycle as the state it belongs to. A state change is due one rising edge after the inputs that select it. The bench drives `opcode`, `alu_zero`, `alu_ovf` and `irq` on the falling edge. It checks the state and every output at that falling edge, before the next rising edge. It then steps one clock and compares the new state with the successor it computed. The sweep covers all 64 opcodes against every combination of zero, overflow and interrupt. Reset is checked both at power-up and in the middle of an instruction.

// File: rtl/mctrap_pkg.sv
package mctrap_pkg;

    localparam int OP_W    = 6;
    localparam int CAUSE_W = 5;
    localparam int ST_W    = 4;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH    = 4'b0000,
        ST_DECODE   = 4'b0001,
        ST_BEQ      = 4'b0010,
        ST_JUMP     = 4'b0011,
        ST_REX      = 4'b0100,
        ST_RWB      = 4'b0101,
        ST_OEX      = 4'b0110,
        ST_OWB      = 4'b0111,
        ST_LADDR    = 4'b1000,
        ST_LMEM     = 4'b1001,
        ST_LWB      = 4'b1010,
        ST_SADDR    = 4'b1011,
        ST_SMEM     = 4'b1100,
        ST_TRAP_RI  = 4'b1101,
        ST_TRAP_OVF = 4'b1110,
        ST_TRAP_INT = 4'b1111
    } mc_state_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OPC_SW    = 6'b101011;

    localparam logic [CAUSE_W-1:0] CAUSE_INT = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_RI  = 5'd10;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF = 5'd12;

    typedef enum logic [1:0] {PCS_ALU, PCS_ALUOUT, PCS_JUMP, PCS_TRAP} pc_src_e;
    typedef enum logic [1:0] {BSEL_REG, BSEL_FOUR, BSEL_IMM, BSEL_IMM_SHL} bsel_e;
    typedef enum logic [1:0] {AF_ADD, AF_SUB, AF_FUNCT, AF_OR} afunc_e;

    typedef struct packed {
        logic                pc_wr;
        logic                pc_wr_cond;
        pc_src_e             pc_src;
        logic                addr_from_alu;
        logic                mem_rd;
        logic                mem_wr;
        logic                ir_load;
        logic                rf_wr;
        logic                rf_dst_rd;
        logic                rf_from_mem;
        logic                alu_a_reg;
        bsel_e               b_sel;
        logic                imm_sign;
        afunc_e              func;
        logic                epc_wr;
        logic                cause_wr;
        logic [CAUSE_W-1:0]  cause;
    } ctrl_t;

    // last state of every instruction: the only place an interrupt is taken
    function automatic logic instr_done(mc_state_e s);
        case (s)
            ST_RWB, ST_OWB, ST_LWB, ST_SMEM, ST_BEQ, ST_JUMP: return 1'b1;
            default:                                          return 1'b0;
        endcase
    endfunction

    function automatic logic is_trap(mc_state_e s);
        return (s == ST_TRAP_RI) || (s == ST_TRAP_OVF) || (s == ST_TRAP_INT);
    endfunction

endpackage

// File: rtl/mctrap_next.sv
module mctrap_next
    import mctrap_pkg::*;
(
    input  mc_state_e             st,
    input  logic [OP_W-1:0]       opcode,
    input  logic                  alu_ovf,
    input  logic                  irq,
    output mc_state_e             nxt
);

    mc_state_e dispatch;

    always_comb begin
        case (opcode)
            OPC_RTYPE: dispatch = ST_REX;
            OPC_ORI:   dispatch = ST_OEX;
            OPC_LW:    dispatch = ST_LADDR;
            OPC_SW:    dispatch = ST_SADDR;
            OPC_BEQ:   dispatch = ST_BEQ;
            OPC_JUMP:  dispatch = ST_JUMP;
            default:   dispatch = ST_TRAP_RI;
        endcase
    end

    always_comb begin
        case (st)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = dispatch;
            ST_REX:    nxt = alu_ovf ? ST_TRAP_OVF : ST_RWB;
            ST_OEX:    nxt = ST_OWB;
            ST_LADDR:  nxt = ST_LMEM;
            ST_LMEM:   nxt = ST_LWB;
            ST_SADDR:  nxt = ST_SMEM;
            default:   nxt = (instr_done(st) && irq) ? ST_TRAP_INT : ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mctrap_strobes.sv
module mctrap_strobes
    import mctrap_pkg::*;
(
    input  mc_state_e st,
    output ctrl_t     c
);

    always_comb begin
        c = '0;
        case (st)
            ST_FETCH: begin
                c.mem_rd  = 1'b1;
                c.ir_load = 1'b1;
                c.b_sel   = BSEL_FOUR;
                c.func    = AF_ADD;
                c.pc_src  = PCS_ALU;
                c.pc_wr   = 1'b1;
            end
            ST_DECODE: begin
                c.b_sel    = BSEL_IMM_SHL;
                c.imm_sign = 1'b1;
            end
            ST_REX: begin
                c.alu_a_reg = 1'b1;
                c.func      = AF_FUNCT;
            end
            ST_RWB: begin
                c.rf_wr     = 1'b1;
                c.rf_dst_rd = 1'b1;
            end
            ST_OEX: begin
                c.alu_a_reg = 1'b1;
                c.b_sel     = BSEL_IMM;
                c.func      = AF_OR;
            end
            ST_OWB: c.rf_wr = 1'b1;
            ST_LADDR, ST_SADDR: begin
                c.alu_a_reg = 1'b1;
                c.b_sel     = BSEL_IMM;
                c.imm_sign  = 1'b1;
            end
            ST_LMEM: begin
                c.mem_rd        = 1'b1;
                c.addr_from_alu = 1'b1;
            end
            ST_LWB: begin
                c.rf_wr       = 1'b1;
                c.rf_from_mem = 1'b1;
            end
            ST_SMEM: begin
                c.mem_wr        = 1'b1;
                c.addr_from_alu = 1'b1;
            end
            ST_BEQ: begin
                c.alu_a_reg  = 1'b1;
                c.func       = AF_SUB;
                c.pc_src     = PCS_ALUOUT;
                c.pc_wr_cond = 1'b1;
            end
            ST_JUMP: begin
                c.pc_wr  = 1'b1;
                c.pc_src = PCS_JUMP;
            end
            ST_TRAP_RI, ST_TRAP_OVF, ST_TRAP_INT: begin
                c.b_sel    = BSEL_FOUR;
                c.func     = AF_SUB;
                c.epc_wr   = 1'b1;
                c.cause_wr = 1'b1;
                c.pc_wr    = 1'b1;
                c.pc_src   = PCS_TRAP;
                c.cause    = (st == ST_TRAP_RI)  ? CAUSE_RI :
                             (st == ST_TRAP_OVF) ? CAUSE_OVF : CAUSE_INT;
            end
            default: c = '0;
        endcase
    end

endmodule

// File: rtl/mctrap_ctrl.sv
module mctrap_ctrl
    import mctrap_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 32'h8000_0080
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    opcode,
    input  logic               alu_zero,
    input  logic               alu_ovf,
    input  logic               irq,
    output logic [ST_W-1:0]    state_q,
    output logic               pc_load,
    output logic [1:0]         pc_src,
    output logic               addr_from_alu,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               ir_load,
    output logic               rf_wr,
    output logic               rf_dst_rd,
    output logic               rf_from_mem,
    output logic               alu_a_reg,
    output logic [1:0]         alu_b_sel,
    output logic               imm_sign,
    output logic [1:0]         alu_func,
    output logic               epc_wr,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause_code,
    output logic [ADDR_W-1:0]  trap_target
);

    mc_state_e st_q;
    mc_state_e st_d;
    ctrl_t     c;

    mctrap_next u_next (
        .st      (st_q),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .irq     (irq),
        .nxt     (st_d)
    );

    mctrap_strobes u_strobes (
        .st (st_q),
        .c  (c)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_FETCH;
        else     st_q <= st_d;
    end

    assign state_q       = st_q;
    assign pc_load       = c.pc_wr | (c.pc_wr_cond & alu_zero);
    assign pc_src        = c.pc_src;
    assign addr_from_alu = c.addr_from_alu;
    assign mem_rd        = c.mem_rd;
    assign mem_wr        = c.mem_wr;
    assign ir_load       = c.ir_load;
    assign rf_wr         = c.rf_wr;
    assign rf_dst_rd     = c.rf_dst_rd;
    assign rf_from_mem   = c.rf_from_mem;
    assign alu_a_reg     = c.alu_a_reg;
    assign alu_b_sel     = c.b_sel;
    assign imm_sign      = c.imm_sign;
    assign alu_func      = c.func;
    assign epc_wr        = c.epc_wr;
    assign cause_wr      = c.cause_wr;
    assign cause_code    = c.cause;
    assign trap_target   = HANDLER_ADDR;

    AST_RESET_FETCH: assert property (@(posedge clk)
        rst |=> st_q == ST_FETCH);                                            // R1
    AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_FETCH |=> st_q == ST_DECODE);                              // R2
    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REX && alu_ovf) |=> (st_q == ST_TRAP_OVF && !rf_wr));     // R5
    AST_BEQ_ZERO: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_BEQ |-> pc_load == alu_zero);                              // R9
    AST_TRAP_STROBES: assert property (@(posedge clk) disable iff (rst)
        is_trap(st_q) |-> (epc_wr && cause_wr && pc_load && pc_src == 2'd3)); // R11
    AST_IRQ_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (irq && !instr_done(st_q)) |=> st_q != ST_TRAP_INT);                  // R12
    AST_TRAP_RETURN: assert property (@(posedge clk) disable iff (rst)
        is_trap(st_q) |=> st_q == ST_FETCH);                                  // R13
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));                                                 // R14

endmodule

// File: tb/mctrap_ctrl_test.sv
module mctrap_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = '0;
    logic        alu_zero = 1'b0;
    logic        alu_ovf = 1'b0;
    logic        irq = 1'b0;
    logic [3:0]  state_q;
    logic        pc_load, addr_from_alu, mem_rd, mem_wr, ir_load;
    logic        rf_wr, rf_dst_rd, rf_from_mem, alu_a_reg, imm_sign;
    logic        epc_wr, cause_wr;
    logic [1:0]  pc_src, alu_b_sel, alu_func;
    logic [4:0]  cause_code;
    logic [31:0] trap_target;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mctrap_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .alu_ovf(alu_ovf), .irq(irq), .state_q(state_q), .pc_load(pc_load),
        .pc_src(pc_src), .addr_from_alu(addr_from_alu), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .ir_load(ir_load), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd),
        .rf_from_mem(rf_from_mem), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
        .imm_sign(imm_sign), .alu_func(alu_func), .epc_wr(epc_wr),
        .cause_wr(cause_wr), .cause_code(cause_code), .trap_target(trap_target)
    );

    logic [22:0] outs;
    assign outs = {pc_load, pc_src, addr_from_alu, mem_rd, mem_wr, ir_load,
                   rf_wr, rf_dst_rd, rf_from_mem, alu_a_reg, alu_b_sel,
                   imm_sign, alu_func, epc_wr, cause_wr, cause_code};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected strobes per state, built from the requirement text
    function automatic logic [22:0] exp_ctrl(input logic [3:0] s, input logic z);
        logic pl = 0, aa = 0, mr = 0, mw = 0, il = 0, rw = 0, rd = 0, rm = 0;
        logic ar = 0, sg = 0, ew = 0, cw = 0;
        logic [1:0] ps = 0, bs = 0, fn = 0;
        logic [4:0] cc = 0;
        case (s)
            4'b0000: begin mr = 1; il = 1; pl = 1; bs = 1; end
            4'b0001: begin bs = 3; sg = 1; end
            4'b0100: begin ar = 1; fn = 2; end
            4'b0101: begin rw = 1; rd = 1; end
            4'b0110: begin ar = 1; bs = 2; fn = 3; end
            4'b0111: begin rw = 1; end
            4'b1000, 4'b1011: begin ar = 1; bs = 2; sg = 1; end
            4'b1001: begin mr = 1; aa = 1; end
            4'b1010: begin rw = 1; rm = 1; end
            4'b1100: begin mw = 1; aa = 1; end
            4'b0010: begin ar = 1; fn = 1; ps = 1; pl = z; end
            4'b0011: begin pl = 1; ps = 2; end
            default: begin
                bs = 1; fn = 1; ew = 1; cw = 1; pl = 1; ps = 3;
                cc = (s == 4'b1101) ? 5'd10 : (s == 4'b1110) ? 5'd12 : 5'd0;
            end
        endcase
        return {pl, ps, aa, mr, mw, il, rw, rd, rm, ar, bs, sg, fn, ew, cw, cc};
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] s, input logic [5:0] op,
                                            input logic ovf, input logic ir);
        case (s)
            4'b0000: return 4'b0001;
            4'b0001: case (op)
                         6'b000000: return 4'b0100;
                         6'b001101: return 4'b0110;
                         6'b100011: return 4'b1000;
                         6'b101011: return 4'b1011;
                         6'b000100: return 4'b0010;
                         6'b000010: return 4'b0011;
                         default:   return 4'b1101;
                     endcase
            4'b0100: return ovf ? 4'b1110 : 4'b0101;
            4'b0110: return 4'b0111;
            4'b1000: return 4'b1001;
            4'b1001: return 4'b1010;
            4'b1011: return 4'b1100;
            4'b0101, 4'b0111, 4'b1010, 4'b1100, 4'b0010, 4'b0011:
                return ir ? 4'b1111 : 4'b0000;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string strobe_req(input logic [3:0] s);
        case (s)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0100, 4'b0101: return "R4";
            4'b0110, 4'b0111: return "R6";
            4'b1000, 4'b1001, 4'b1010: return "R7";
            4'b1011, 4'b1100: return "R8";
            4'b0010: return "R9";
            4'b0011: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic string move_req(input logic [3:0] prev);
        case (prev)
            4'b0000: return "R2";
            4'b0001: return "R3";
            4'b0100: return "R5";
            4'b0101, 4'b0111, 4'b1010, 4'b1100, 4'b0010, 4'b0011: return "R12";
            4'b1101, 4'b1110, 4'b1111: return "R13";
            default: return "R12";
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_s;
        logic [3:0] prev_s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "reset state", {28'd0, state_q}, 32'h0);
        check("R1", "reset strobes", {9'd0, outs}, {9'd0, exp_ctrl(4'b0000, 1'b0)});
        check("R11", "handler address", trap_target, 32'h8000_0080);

        for (int op = 0; op < 64; op++) begin
            for (int c = 0; c < 8; c++) begin
                opcode   = op[5:0];
                alu_zero = c[0];
                alu_ovf  = c[1];
                irq      = c[2];
                exp_s    = 4'b0000;
                prev_s   = 4'b0000;
                for (int k = 0; k < 8; k++) begin
                    if (k == 0)
                        check("R13", "state at start", {28'd0, state_q}, {28'd0, exp_s});
                    else
                        check(move_req(prev_s), "state", {28'd0, state_q}, {28'd0, exp_s});
                    check(strobe_req(exp_s), "strobes (R14)", {9'd0, outs},
                          {9'd0, exp_ctrl(exp_s, alu_zero)});
                    prev_s = exp_s;
                    exp_s  = exp_next(exp_s, opcode, alu_ovf, irq);
                    @(negedge clk);
                    if (exp_s == 4'b0000) break;
                end
            end
        end

        // reset in the middle of a load
        opcode = 6'b100011; alu_ovf = 0; irq = 0; alu_zero = 0;
        check("R1", "pre-reset state", {28'd0, state_q}, 32'h0);
        @(negedge clk);
        @(negedge clk);
        check("R3", "load dispatch", {28'd0, state_q}, 32'h8);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "mid-instruction reset", {28'd0, state_q}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule